// File: doc/BRIEF.md
# Handshaked Bus Write Master

This block is the initiator side of a parallel bus that has separate address and data lines and a two-wire request/ready handshake. A local command port hands it one target address, a packed vector of four data words and a one-cycle start pulse. The master then raises the bus lines in a fixed sequence. First comes the write-direction line. The address follows on the next cycle and the request on the cycle after that. The master then waits for the target to acknowledge with ready, streams the four words one per cycle, and lets go of the bus once the target drops ready.

Completion is reported by a one-cycle done pulse. If the target never answers, a bounded wait aborts the transfer and raises a sticky error flag that holds until the next accepted command. A busy output tells the local side when a new command may be issued. Start pulses that arrive while busy is high are discarded.

Top module: `hs_wr_master`

## Requirements
- R1: After reset, bus_wr, bus_addr_oe, bus_req, bus_data_oe, busy, done and err are all low, and bus_addr and bus_data are zero.
- R2: A start pulse seen while idle makes bus_wr high on the next cycle, with the address and request not yet driven.
- R3: One cycle after bus_wr rises, bus_addr_oe rises and bus_addr carries the latched command address. Whenever bus_addr_oe is low, bus_addr is zero.
- R4: One cycle after the address is driven, bus_req rises.
- R5: No data is placed on the bus until bus_rdy has been sampled high with the request asserted. Ready is sampled on each of up to 16 clock edges after the request rises.
- R6: The cycle after ready is first sampled high, bus_data_oe goes high for exactly four cycles. Beat j carries cmd_data[j*16 +: 16], with beat 0 first. Whenever bus_data_oe is low, bus_data is zero.
- R7: bus_wr, bus_addr_oe, bus_req and the bus_addr value stay unchanged from their assertion until release.
- R8: After the four beats, the first edge that samples bus_rdy low releases the bus. On the next cycle every bus line is low, done is high for exactly one cycle, and busy is low.
- R9: If bus_rdy is low on all 16 sampled edges after the request rises, the cycle after the 16th such edge has all bus lines low, busy low and err high. err stays high until the next start is accepted.
- R10: A start pulse while busy is high has no effect on the bus lines, the address, the data or the timing of the transfer in progress.
- R11: busy is high from the cycle after an accepted start until the release or abort cycle, where it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle command start pulse |
| cmd_addr | input | 16 | Target address of the write |
| cmd_data | input | 64 | Four packed data words, word 0 in the low bits |
| bus_rdy | input | 1 | Target acknowledge / hold line |
| bus_wr | output | 1 | Write-direction line |
| bus_addr_oe | output | 1 | Address lines are being driven |
| bus_addr | output | 16 | Address lines |
| bus_req | output | 1 | Request line |
| bus_data_oe | output | 1 | Data lines are being driven |
| bus_data | output | 16 | Data lines |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, sticky until next accepted start |

## Verification
A wrong sequencer state appears on the bus lines within one cycle, because every line is decoded straight from the registered state. A skipped or repeated phase shows as a line rising a cycle early or late against the start pulse. A wrong beat counter shows as the wrong word or a data window of the wrong length on the very next cycle. A wrong timeout count moves the abort by one or more cycles, which the ready delays of 15 and 16 samples expose at the boundary. A start that leaks into a busy transfer changes bus_addr or restarts the phase order on the following cycle.

// File: rtl/hswm_pkg.sv
package hswm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DIR  = 3'd1,
    ST_ADDR = 3'd2,
    ST_WAIT = 3'd3,
    ST_DATA = 3'd4,
    ST_REL  = 3'd5
  } hswm_state_e;

  // true on the last permitted wait sample
  function automatic logic wait_expired(input int cnt, input int limit);
    return cnt == limit - 1;
  endfunction

  // true on the final data beat
  function automatic logic beat_final(input int beat, input int nbeat);
    return beat == nbeat - 1;
  endfunction

  // bit offset of a beat inside the packed data vector
  function automatic int beat_lsb(input int beat, input int width);
    return beat * width;
  endfunction

endpackage

// File: rtl/hswm_tmo.sv
module hswm_tmo #(
  parameter int TMO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic fire
);
  localparam int CW = $clog2(TMO + 1);

  logic [CW-1:0] cnt_q;

  assign fire = run && hswm_pkg::wait_expired(int'(cnt_q), TMO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run && !fire) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/hswm_seq.sv
module hswm_seq
  import hswm_pkg::*;
#(
  parameter int NBEAT = 4,
  localparam int BW = (NBEAT > 1) ? $clog2(NBEAT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rdy,
  input  logic          tmo_fire,
  output hswm_state_e   state,
  output logic [BW-1:0] beat,
  output logic          start_acc,
  output logic          tmo_clr,
  output logic          tmo_run,
  output logic          done,
  output logic          err
);
  hswm_state_e st_q, st_d;
  logic [BW-1:0] beat_q;
  logic last_beat;
  logic rel_evt;

  assign state     = st_q;
  assign beat      = beat_q;
  assign start_acc = (st_q == ST_IDLE) && start;
  assign last_beat = beat_final(int'(beat_q), NBEAT);
  assign rel_evt   = (st_q == ST_REL) && !rdy;
  assign tmo_clr   = (st_q != ST_WAIT);
  assign tmo_run   = (st_q == ST_WAIT) && !rdy;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_DIR;
      ST_DIR:  st_d = ST_ADDR;
      ST_ADDR: st_d = ST_WAIT;
      ST_WAIT: begin
        if (rdy)           st_d = ST_DATA;
        else if (tmo_fire) st_d = ST_IDLE;
      end
      ST_DATA: if (last_beat) st_d = ST_REL;
      ST_REL:  if (!rdy) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= rel_evt;
      if (st_q == ST_DATA) beat_q <= beat_q + BW'(1);
      else                 beat_q <= '0;
      if (start_acc)     err <= 1'b0;
      else if (tmo_fire) err <= 1'b1;
    end
  end
endmodule

// File: rtl/hswm_drive.sv
module hswm_drive
  import hswm_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int NBEAT = 4,
  localparam int BW = (NBEAT > 1) ? $clog2(NBEAT) : 1,
  localparam int VW = NBEAT * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] cmd_addr,
  input  logic [VW-1:0] cmd_data,
  input  hswm_state_e   state,
  input  logic [BW-1:0] beat,
  output logic          bus_wr,
  output logic          bus_addr_oe,
  output logic [AW-1:0] bus_addr,
  output logic          bus_req,
  output logic          bus_data_oe,
  output logic [DW-1:0] bus_data
);
  logic [AW-1:0] addr_q;
  logic [VW-1:0] data_q;
  logic [DW-1:0] words [NBEAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= cmd_addr;
      data_q <= cmd_data;
    end
  end

  for (genvar g = 0; g < NBEAT; g++) begin : g_word
    assign words[g] = data_q[beat_lsb(g, DW) +: DW];
  end

  always_comb begin
    bus_wr      = (state != ST_IDLE);
    bus_addr_oe = (state != ST_IDLE) && (state != ST_DIR);
    bus_req     = (state == ST_WAIT) || (state == ST_DATA) || (state == ST_REL);
    bus_data_oe = (state == ST_DATA);
    bus_addr    = bus_addr_oe ? addr_q : '0;
    bus_data    = bus_data_oe ? words[beat] : '0;
  end
endmodule

// File: rtl/hs_wr_master.sv
module hs_wr_master
  import hswm_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int NBEAT = 4,
  parameter int TMO   = 16,
  localparam int BW = (NBEAT > 1) ? $clog2(NBEAT) : 1,
  localparam int VW = NBEAT * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_addr,
  input  logic [VW-1:0] cmd_data,
  input  logic          bus_rdy,
  output logic          bus_wr,
  output logic          bus_addr_oe,
  output logic [AW-1:0] bus_addr,
  output logic          bus_req,
  output logic          bus_data_oe,
  output logic [DW-1:0] bus_data,
  output logic          busy,
  output logic          done,
  output logic          err
);
  hswm_state_e   st;
  logic [BW-1:0] beat;
  logic          start_acc;
  logic          tmo_clr;
  logic          tmo_run;
  logic          tmo_fire;

  hswm_seq #(.NBEAT(NBEAT)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .rdy(bus_rdy),
    .tmo_fire(tmo_fire), .state(st), .beat(beat), .start_acc(start_acc),
    .tmo_clr(tmo_clr), .tmo_run(tmo_run), .done(done), .err(err)
  );

  hswm_tmo #(.TMO(TMO)) tmo_i (
    .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .run(tmo_run), .fire(tmo_fire)
  );

  hswm_drive #(.AW(AW), .DW(DW), .NBEAT(NBEAT)) drv_i (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .state(st), .beat(beat), .bus_wr(bus_wr),
    .bus_addr_oe(bus_addr_oe), .bus_addr(bus_addr), .bus_req(bus_req),
    .bus_data_oe(bus_data_oe), .bus_data(bus_data)
  );

  assign busy = (st != ST_IDLE);
endmodule

module hswm_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rdy,
  input logic          bus_wr,
  input logic          bus_addr_oe,
  input logic [AW-1:0] bus_addr,
  input logic          bus_req,
  input logic          bus_data_oe,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          tmo_fire
);
  a_r3_addr_under_wr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_oe |-> bus_wr);

  a_r4_req_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(bus_addr_oe));

  a_r5_data_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_data_oe) |-> $past(bus_rdy) && $past(bus_req));

  a_r7_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> $stable(bus_addr));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !bus_wr && !bus_req);

  a_r9_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> err && !bus_wr && !busy);

  a_r11_busy_wr: assert property (@(posedge clk) disable iff (!rst_n)
    busy == bus_wr);
endmodule

bind hs_wr_master hswm_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rdy(bus_rdy), .bus_wr(bus_wr),
  .bus_addr_oe(bus_addr_oe), .bus_addr(bus_addr), .bus_req(bus_req),
  .bus_data_oe(bus_data_oe), .busy(busy), .done(done), .err(err),
  .tmo_fire(tmo_fire)
);

// File: tb/hs_wr_master_tb_top.sv
module hs_wr_master_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NB = 4;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [NB*DW-1:0] cmd_data = '0;
  logic bus_rdy = 1'b0;
  logic bus_wr, bus_addr_oe, bus_req, bus_data_oe, busy, done, err;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;

  int n_run = 0;
  int n_fail = 0;
  logic err_exp = 1'b0;

  always #4 clk = ~clk;

  hs_wr_master #(.AW(AW), .DW(DW), .NBEAT(NB), .TMO(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .bus_rdy(bus_rdy), .bus_wr(bus_wr),
    .bus_addr_oe(bus_addr_oe), .bus_addr(bus_addr), .bus_req(bus_req),
    .bus_data_oe(bus_data_oe), .bus_data(bus_data), .busy(busy),
    .done(done), .err(err)
  );

  function automatic logic [DW-1:0] word_of(input int seed, input int j);
    return DW'(seed * 37 + j * 4099 + 1);
  endfunction

  task automatic chk(input string req, input int ph, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s phase %0d actual %0h expected %0h", req, ph, act, exp);
    end
  endtask

  // d: ready low for d wait samples (d >= TMO means never); h: ready cycles held into release
  task automatic run_txn(input int seed, input int d, input int h, input int ign_at);
    logic [AW-1:0] a;
    logic [NB*DW-1:0] dv;
    bit to;
    int n0, r;
    a = AW'(seed * 613 + 5);
    for (int j = 0; j < NB; j++) dv[j*DW +: DW] = word_of(seed, j);
    to = (d >= TMO);
    n0 = to ? 1000 : 3 + d;
    r  = to ? TMO + 2 : n0 + 4 + h;
    @(negedge clk);
    cmd_start = 1'b1; cmd_addr = a; cmd_data = dv;
    for (int p = 0; p <= r + 1; p++) begin
      @(negedge clk);
      cmd_start = 1'b0; cmd_addr = a; cmd_data = dv;
      if (p == ign_at) begin
        cmd_start = 1'b1; cmd_addr = ~a; cmd_data = ~dv;
      end
      if (to && p >= r) err_exp = 1'b1;
      else if (p == 0)  err_exp = 1'b0;
      chk("R2/R11 bus_wr", p, 32'(bus_wr), 32'(p < r));
      chk("R11 busy", p, 32'(busy), 32'(p < r));
      chk("R3 bus_addr_oe", p, 32'(bus_addr_oe), 32'(p >= 1 && p < r));
      chk("R3/R7/R10 bus_addr", p, 32'(bus_addr), (p >= 1 && p < r) ? 32'(a) : 32'd0);
      chk("R4/R7 bus_req", p, 32'(bus_req), 32'(p >= 2 && p < r));
      chk("R5/R6 bus_data_oe", p, 32'(bus_data_oe), 32'(!to && p >= n0 && p <= n0 + 3));
      chk("R6/R10 bus_data", p, 32'(bus_data),
          (!to && p >= n0 && p <= n0 + 3) ? 32'(word_of(seed, p - n0)) : 32'd0);
      chk("R8 done", p, 32'(done), 32'(!to && p == r));
      chk("R9 err", p, 32'(err), 32'(err_exp));
      bus_rdy = !to && (p >= 2 + d) && (p < n0 + 3 + h);
    end
    bus_rdy = 1'b0;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 lines", -1, {25'd0, bus_wr, bus_addr_oe, bus_req, bus_data_oe, busy, done, err}, 32'd0);
    chk("R1 addr", -1, 32'(bus_addr), 32'd0);
    chk("R1 data", -1, 32'(bus_data), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", -1, {25'd0, bus_wr, bus_addr_oe, bus_req, bus_data_oe, busy, done, err}, 32'd0);
    // R5/R6 sweep of ready delays and release holds
    for (int d = 0; d < TMO; d++)
      for (int h = 1; h <= 3; h += 2)
        run_txn(d * 7 + h, d, h, -1);
    // R9 timeout at 16 samples, then recovery clears err
    run_txn(91, TMO, 1, -1);
    repeat (3) begin
      @(negedge clk);
      chk("R9 err sticky", -1, 32'(err), 32'd1);
    end
    run_txn(92, 15, 2, -1);
    run_txn(93, TMO + 4, 1, -1);
    // R10 start while busy at several phases
    run_txn(94, 3, 2, 1);
    run_txn(95, 4, 3, 8);
    run_txn(96, 2, 4, 12);
    run_txn(97, TMO, 1, 10);
    run_txn(98, 0, 1, -1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule